// File: doc/BRIEF.md
# Compact Sample Packet Deframer

This block turns a byte stream into decoded sample packets. Each packet has eleven bytes. The first ten bytes carry seven payload bits each and have the top bit clear. The eleventh byte has the top bit set, and that set bit is the only boundary marker in the stream. Bytes come in on an 8-bit bus qualified by a valid strobe, for example from a serial receiver. The block has no back-pressure.

From each packet the block recovers:
- a 6-bit sequence counter,
- an 8-bit auxiliary value,
- six 10-bit samples.

Sample channels are handled in pairs. Each pair has two low-part bytes followed by one shared byte that holds the upper three bits of both channels. After reset the block searches for a marker. It treats the byte after the marker as the first byte of a packet, and it finds packet boundaries again after any framing fault. All decoded fields update together, in the same cycle as a one-cycle packet-valid pulse. Faults show as a one-cycle framing-error pulse. A break in the sequence count shows as a gap flag that comes with the packet-valid pulse.

Top module: `pkt_deframer`

## Requirements
- R1: After reset, and after any fault that returns the block to searching, bytes with bit 7 clear are discarded without any output pulse. The first byte with bit 7 set locks the block, and the next accepted byte is packet byte 1.
- R2: Byte 1 bits 6:1 are the sequence counter `seq`. `aux` is {byte 1 bit 0, byte 2 bits 6:0}, so byte 1 bit 0 is aux bit 7.
- R3: For pair p (0..2), bytes 3+3p and 4+3p give the low 7 bits of channels 2p and 2p+1. Byte 5+3p gives the upper bits: bits 6:4 for channel 2p and bits 2:0 for channel 2p+1. Channel k appears on `ch_data[10k+9:10k]`.
- R4: `pkt_valid` is high for exactly one cycle, in the cycle after byte 11 of a valid packet is accepted. `seq`, `aux` and `ch_data` change only in that cycle and hold at all other times.
- R5: A byte with bit 7 set at positions 1 to 10 gives a one-cycle `frame_err` pulse and drops the partial packet. The block stays locked and treats the next byte as byte 1.
- R6: If bit 3 of a shared byte (bytes 5, 8 or 11) is set, the block raises `frame_err`, drops the packet and returns to searching.
- R7: If byte 11 has bit 7 clear, the block raises `frame_err`, drops the packet and returns to searching.
- R8: `seq_gap` is high with `pkt_valid` when the packet's counter is not the previous packet's counter plus one, modulo 64.
- R9: The first valid packet after the block locks from searching never raises `seq_gap`. A resynchronisation under R5 does not count as a new lock.
- R10: Bytes presented while `in_valid` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Incoming stream byte |
| in_valid | input | 1 | Qualifies in_byte for one cycle |
| seq | output | 6 | Sequence counter of the last valid packet |
| aux | output | 8 | Auxiliary value of the last valid packet |
| ch_data | output | 60 | Six 10-bit samples, channel k at bits 10k+9:10k |
| pkt_valid | output | 1 | One-cycle pulse when a packet is published |
| frame_err | output | 1 | One-cycle pulse on a framing fault |
| seq_gap | output | 1 | Sequence break, valid together with pkt_valid |

## Verification
A position counter that has drifted shows on the next packet as samples taken from the wrong bytes. It also shows as a `frame_err` pulse no later than the next marker byte, because the marker then lands at a position other than 11. A search/locked flag stuck in the wrong value shows as a missing or extra packet within one packet length. A stale remembered counter shows only on the following packet, as a wrong `seq_gap` value. For this reason each scenario sends at least two packets back to back and checks every field and flag after each packet.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
    localparam int BYTE_W    = 8;
    localparam int PAY_W     = 7;
    localparam int PKT_BYTES = 11;
    localparam int HDR_BYTES = 2;
    localparam int NUM_CH    = 6;
    localparam int NUM_PAIRS = NUM_CH / 2;
    localparam int HI_W      = 3;
    localparam int SAMP_W    = PAY_W + HI_W;
    localparam int SEQ_W     = 6;
    localparam int AUX_W     = 8;
    localparam int POS_W     = $clog2(PKT_BYTES);
    localparam int MARK_BIT  = 7;
    localparam int RSV_BIT   = 3;

    typedef enum logic {ST_HUNT, ST_RECV} dfr_state_e;

    typedef struct packed {
        dfr_state_e                             state;
        logic [POS_W-1:0]                       pos;
        logic [PKT_BYTES-2:0][PAY_W-1:0]        held;
        logic                                   have_prev;
        logic [SEQ_W-1:0]                       seq;
        logic [AUX_W-1:0]                       aux;
        logic [NUM_CH*SAMP_W-1:0]               ch;
        logic                                   pkt_valid;
        logic                                   frame_err;
        logic                                   seq_gap;
    } dfr_regs_t;
endpackage

// File: rtl/pkt_byte_check.sv
module pkt_byte_check
    import pkt_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [POS_W-1:0]  pos,
    output logic              is_marker,
    output logic              is_last,
    output logic              rsv_bad
);
    localparam int FIRST_SHARED = HDR_BYTES + 2;

    logic shared_pos;

    always_comb begin
        shared_pos = 1'b0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (int'(pos) == FIRST_SHARED + 3 * p) shared_pos = 1'b1;
        end
        is_marker = byte_in[MARK_BIT];
        is_last   = (pos == POS_W'(PKT_BYTES - 1));
        rsv_bad   = shared_pos && byte_in[RSV_BIT];
    end
endmodule

// File: rtl/pkt_field_unpack.sv
module pkt_field_unpack
    import pkt_pkg::*;
(
    input  logic [PKT_BYTES-1:0][PAY_W-1:0] pay,
    output logic [SEQ_W-1:0]                seq,
    output logic [AUX_W-1:0]                aux,
    output logic [NUM_CH*SAMP_W-1:0]        ch
);
    assign seq = pay[0][PAY_W-1:1];
    assign aux = {pay[0][0], pay[1]};

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int BASE = HDR_BYTES + 3 * p;
        logic [PAY_W-1:0] shared_b;
        assign shared_b = pay[BASE + 2];
        assign ch[(2*p)*SAMP_W +: SAMP_W]   = {shared_b[6:4], pay[BASE]};
        assign ch[(2*p+1)*SAMP_W +: SAMP_W] = {shared_b[2:0], pay[BASE + 1]};
    end
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
    import pkt_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                in_byte,
    input  logic                      in_valid,
    output logic [5:0]                seq,
    output logic [7:0]                aux,
    output logic [59:0]               ch_data,
    output logic                      pkt_valid,
    output logic                      frame_err,
    output logic                      seq_gap
);
    dfr_regs_t r_q, r_d;

    logic is_marker, is_last, rsv_bad;
    logic [PKT_BYTES-1:0][PAY_W-1:0] pay_all;
    logic [SEQ_W-1:0]                 u_seq;
    logic [AUX_W-1:0]                 u_aux;
    logic [NUM_CH*SAMP_W-1:0]         u_ch;

    pkt_byte_check u_chk (
        .byte_in   (in_byte),
        .pos       (r_q.pos),
        .is_marker (is_marker),
        .is_last   (is_last),
        .rsv_bad   (rsv_bad)
    );

    assign pay_all = {in_byte[PAY_W-1:0], r_q.held};

    pkt_field_unpack u_unp (
        .pay (pay_all),
        .seq (u_seq),
        .aux (u_aux),
        .ch  (u_ch)
    );

    always_comb begin
        r_d           = r_q;
        r_d.pkt_valid = 1'b0;
        r_d.frame_err = 1'b0;
        r_d.seq_gap   = 1'b0;
        if (in_valid) begin
            unique case (r_q.state)
                ST_HUNT: begin
                    if (is_marker) begin
                        r_d.state     = ST_RECV;
                        r_d.pos       = '0;
                        r_d.have_prev = 1'b0;
                    end
                end
                ST_RECV: begin
                    if (!is_last) begin
                        if (is_marker) begin
                            r_d.frame_err = 1'b1;
                            r_d.pos       = '0;
                        end else if (rsv_bad) begin
                            r_d.frame_err = 1'b1;
                            r_d.state     = ST_HUNT;
                        end else begin
                            r_d.held[r_q.pos] = in_byte[PAY_W-1:0];
                            r_d.pos           = r_q.pos + 1'b1;
                        end
                    end else if (!is_marker || rsv_bad) begin
                        r_d.frame_err = 1'b1;
                        r_d.state     = ST_HUNT;
                    end else begin
                        r_d.pkt_valid = 1'b1;
                        r_d.seq_gap   = r_q.have_prev && (u_seq != r_q.seq + 1'b1);
                        r_d.seq       = u_seq;
                        r_d.aux       = u_aux;
                        r_d.ch        = u_ch;
                        r_d.have_prev = 1'b1;
                        r_d.pos       = '0;
                    end
                end
                default: r_d.state = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign seq       = r_q.seq;
    assign aux       = r_q.aux;
    assign ch_data   = r_q.ch;
    assign pkt_valid = r_q.pkt_valid;
    assign frame_err = r_q.frame_err;
    assign seq_gap   = r_q.seq_gap;

    // R4
    pv_after_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(in_valid && in_byte[MARK_BIT]));
    // R4
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> ($stable(seq) && $stable(aux) && $stable(ch_data)));
    // R5
    pv_fe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && frame_err));
    // R10
    err_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid || frame_err) |-> $past(in_valid));
    // R8
    gap_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_gap |-> pkt_valid);
    // R8
    gap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_gap |-> (seq != $past(seq) + 1'b1));
endmodule

// File: tb/sim_pkt_deframer.sv
module sim_pkt_deframer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic [5:0]  seq;
    logic [7:0]  aux;
    logic [59:0] ch_data;
    logic        pkt_valid, frame_err, seq_gap;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] pk [0:10];
    logic [9:0] smp [0:5];

    always #5 clk = ~clk;

    pkt_deframer u0 (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .seq(seq), .aux(aux), .ch_data(ch_data),
        .pkt_valid(pkt_valid), .frame_err(frame_err), .seq_gap(seq_gap)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_byte  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'h00;
    endtask

    task automatic make_pkt(input logic [5:0] s, input logic [7:0] a, input int salt);
        for (int k = 0; k < 6; k++) smp[k] = 10'((salt * 97 + k * 181 + 5) % 1024);
        pk[0] = {1'b0, s, a[7]};
        pk[1] = {1'b0, a[6:0]};
        for (int p = 0; p < 3; p++) begin
            pk[2+3*p] = {1'b0, smp[2*p][6:0]};
            pk[3+3*p] = {1'b0, smp[2*p+1][6:0]};
            pk[4+3*p] = {(p == 2), smp[2*p][9:7], 1'b0, smp[2*p+1][9:7]};
        end
    endtask

    function automatic logic [59:0] exp_ch();
        logic [59:0] v;
        for (int k = 0; k < 6; k++) v[k*10 +: 10] = smp[k];
        return v;
    endfunction

    task automatic send_pkt_check(input logic [5:0] s, input logic [7:0] a, input int salt,
                                  input logic gap_exp, input string tag);
        make_pkt(s, a, salt);
        for (int i = 0; i < 10; i++) begin
            send_byte(pk[i]);
            chk({tag, " R4 no early valid"}, {62'd0, pkt_valid, frame_err}, 64'd0);
        end
        send_byte(pk[10]);
        chk({tag, " R4 pkt_valid"}, pkt_valid, 1);
        chk({tag, " R2 seq"}, seq, s);
        chk({tag, " R2 aux"}, aux, a);
        chk({tag, " R3 channels"}, ch_data, exp_ch());
        chk({tag, " R8 seq_gap"}, seq_gap, gap_exp);
        @(negedge clk);
        chk({tag, " R4 one-cycle pulse"}, pkt_valid, 0);
    endtask

    task automatic t_reset();
        chk("R4 reset valid", pkt_valid, 0);
        chk("R4 reset err", frame_err, 0);
        chk("R2 reset seq", seq, 0);
    endtask

    task automatic t_lock();
        send_byte(8'h12); chk("R1 junk ignored", {pkt_valid, frame_err}, 0);
        send_byte(8'h7f); chk("R1 junk ignored", {pkt_valid, frame_err}, 0);
        @(negedge clk); in_byte = 8'h80; @(negedge clk); in_byte = 8'h00;
        chk("R10 strobe low ignored", {pkt_valid, frame_err}, 0);
        send_byte(8'h80); chk("R1 marker locks quietly", {pkt_valid, frame_err}, 0);
        send_pkt_check(6'd5, 8'hA3, 1, 1'b0, "R9 first after lock");
        send_pkt_check(6'd6, 8'h3C, 2, 1'b0, "R8 consecutive");
        send_pkt_check(6'd8, 8'hFF, 3, 1'b1, "R8 gap");
    endtask

    task automatic t_early_marker();
        make_pkt(6'd40, 8'h11, 4);
        for (int i = 0; i < 5; i++) send_byte(pk[i]);
        send_byte(8'h85);
        chk("R5 frame_err", frame_err, 1);
        chk("R5 no valid", pkt_valid, 0);
        chk("R4 hold seq", seq, 8);
        send_pkt_check(6'd9, 8'h5A, 5, 1'b0, "R5 relock keeps history R9");
    endtask

    task automatic t_reserved();
        make_pkt(6'd10, 8'h22, 6);
        pk[4][3] = 1'b1;
        for (int i = 0; i < 4; i++) send_byte(pk[i]);
        send_byte(pk[4]);
        chk("R6 frame_err", frame_err, 1);
        for (int i = 5; i < 11; i++) begin
            send_byte(pk[i]);
            chk("R6 hunting quiet", {pkt_valid, frame_err}, 0);
        end
        chk("R4 hold seq", seq, 9);
        send_pkt_check(6'd20, 8'h80, 7, 1'b0, "R6 R9 relock");
        make_pkt(6'd21, 8'h01, 8);
        pk[10][3] = 1'b1;
        for (int i = 0; i < 11; i++) send_byte(pk[i]);
        chk("R6 last byte reserved", frame_err, 1);
        chk("R6 no valid", pkt_valid, 0);
    endtask

    task automatic t_no_end();
        send_byte(8'h80);
        send_pkt_check(6'd30, 8'h44, 9, 1'b0, "R9 relock");
        make_pkt(6'd31, 8'h55, 10);
        pk[10][7] = 1'b0;
        for (int i = 0; i < 11; i++) send_byte(pk[i]);
        chk("R7 frame_err", frame_err, 1);
        make_pkt(6'd32, 8'h66, 11);
        for (int i = 0; i < 11; i++) begin
            send_byte(pk[i]);
            if (i < 10) chk("R7 hunting quiet", {pkt_valid, frame_err}, 0);
        end
        chk("R7 marker only relocks", pkt_valid, 0);
        send_pkt_check(6'd63, 8'h07, 12, 1'b0, "R7 R9 after hunt");
        send_pkt_check(6'd0, 8'h70, 13, 1'b0, "R8 wrap");
        send_pkt_check(6'd0, 8'h70, 14, 1'b1, "R8 repeat");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_early_marker();
        t_reserved();
        t_no_end();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule